// File: doc/BRIEF.md
# Source-Routed Wormhole Input Controller

This block is the receive side of one port of a five-port mesh router that is steered by source routing. Flits of 34 bits arrive over a valid/ready handshake. Bit 33 marks the first flit of a packet and bit 32 marks the last. In a header, bits 31:18 hold the route as a string of two-bit direction steps, and bits 17:0 hold payload. In a body flit, bits 31:0 are all payload.

When no route is held, the controller reads the lowest step of a header's route field and turns it into a one-hot request toward one of the four outputs other than its own port. The route field is shifted down by one step before the header leaves, so the next router finds its own step at the bottom. Wormhole switching then holds that output for every later flit until the end flit has gone through. The path from input to output is combinational, so a flit crosses the block in the same cycle it is accepted. Only the route and an error flag are kept in registers.

A body flit that arrives while no route is held has no destination. It is accepted and discarded, and a sticky error flag is raised. The router instantiates one controller per port, each with its own port index.

Top module: `srp_input_ctrl`

## Requirements
- R1: While no route is held and a flit with bit 33 set is valid, out_req is one-hot on output index d when d < PORT_ID, and on index d+1 otherwise. Here d is input bits 19:18.
- R2: A header routed from the idle state leaves with bits 31:18 equal to {2'b00, input bits 31:20}. Bits 33:32 and 17:0 pass through unchanged.
- R3: in_ready equals the out_ready bit of the requested output, or of the held output. A flit that is not accepted changes no state.
- R4: After a header without bit 32 is accepted, every later flit is sent unchanged to the same output, whatever its bits 19:18 hold, until the end flit is accepted.
- R5: Accepting a flit with bit 32 set while a route is held releases the route from the next cycle on.
- R6: A header with both bit 33 and bit 32 set is routed and released in the same cycle. The next flit is decoded as if the block were idle.
- R7: A valid flit with bit 33 clear while no route is held is accepted (in_ready high) with out_req all zero. err_drop is high from the next cycle and stays high until reset.
- R8: A flit with bit 33 set that arrives while a route is held is sent unchanged on the held output. It is not decoded again.
- R9: After reset no route is held, err_drop is low, and out_req is zero.
- R10: out_req has at most one bit set, and is zero whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Incoming flit accepted |
| in_flit | input | 34 | Incoming flit |
| out_req | output | NPORTS | One-hot flit-valid request per output |
| out_ready | input | NPORTS | Per-output readiness |
| out_flit | output | 34 | Outgoing flit, route field shifted on headers |
| err_drop | output | 1 | Sticky flag: body flit seen with no route |

## Verification
Two functions can fall in one cycle: the release of a held route and the decode of a new header. A one-flit packet in every cycle provokes this, because each cycle then both decodes a route and gives it up. The bench sends such a stream over all four step values. It requires each flit to be steered by its own step and never by the step of the flit before, and it requires no stale request to remain once the stream stops. The same coincidence comes up again when a stalled header is followed by a body flit. That body flit must be dropped rather than steered by the header that was never taken.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int FLIT_W  = 34;
  localparam int PATH_W  = 14;
  localparam int LOAD_W  = 18;
  localparam int STEP_W  = 2;

  typedef struct packed {
    logic              first;
    logic              last;
    logic [PATH_W-1:0] path;
    logic [LOAD_W-1:0] load;
  } hdr_view_t;
endpackage

// File: rtl/srp_path_decode.sv
module srp_path_decode
  import srp_pkg::*;
#(
  parameter int NPORTS  = 5,
  parameter int PORT_ID = 0
) (
  input  hdr_view_t         hdr_in,
  output logic [NPORTS-1:0] dest_oh,
  output hdr_view_t         hdr_out
);
  logic [STEP_W-1:0] step;
  int                dest_idx;

  assign step = hdr_in.path[STEP_W-1:0];

  // Skip over the arrival port: steps name the remaining outputs in order.
  always_comb begin
    if (int'(step) < PORT_ID) dest_idx = int'(step);
    else                      dest_idx = int'(step) + 1;
  end

  for (genvar o = 0; o < NPORTS; o++) begin : g_dest
    assign dest_oh[o] = (dest_idx == o);
  end

  always_comb begin
    hdr_out      = hdr_in;
    hdr_out.path = hdr_in.path >> STEP_W;
  end
endmodule

// File: rtl/srp_route_hold.sv
module srp_route_hold #(
  parameter int NPORTS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              release_rt,
  input  logic [NPORTS-1:0] new_sel,
  output logic              held,
  output logic [NPORTS-1:0] sel
);
  logic              held_d;
  logic [NPORTS-1:0] sel_d;
  logic              sel_en;

  assign sel_en = take;

  always_comb begin
    held_d = held;
    if (take)            held_d = 1'b1;
    else if (release_rt) held_d = 1'b0;
  end

  always_comb begin
    sel_d = sel;
    if (sel_en) sel_d = new_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      sel  <= '0;
    end else begin
      held <= held_d;
      sel  <= sel_d;
    end
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_rt) |=> (held && $stable(sel)));
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && release_rt) |=> !held);
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> $onehot0(sel));
endmodule

// File: rtl/srp_drop_flag.sv
module srp_drop_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  output logic err
);
  logic err_d;

  always_comb err_d = err | drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_d;
  end

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/srp_input_ctrl.sv
module srp_input_ctrl
  import srp_pkg::*;
#(
  parameter int NPORTS  = 5,
  parameter int PORT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [33:0]       in_flit,
  output logic [NPORTS-1:0] out_req,
  input  logic [NPORTS-1:0] out_ready,
  output logic [33:0]       out_flit,
  output logic              err_drop
);
  hdr_view_t         hv_in, hv_out;
  logic [NPORTS-1:0] dest_oh, sel;
  logic              held, fire, take, release_rt, drop;

  assign hv_in = hdr_view_t'(in_flit);

  srp_path_decode #(.NPORTS(NPORTS), .PORT_ID(PORT_ID)) u_dec (
    .hdr_in (hv_in),
    .dest_oh(dest_oh),
    .hdr_out(hv_out)
  );

  always_comb begin
    if (held) begin
      out_req  = in_valid ? sel : '0;
      in_ready = |(sel & out_ready);
      out_flit = in_flit;
    end else if (hv_in.first) begin
      out_req  = in_valid ? dest_oh : '0;
      in_ready = |(dest_oh & out_ready);
      out_flit = FLIT_W'(hv_out);
    end else begin
      out_req  = '0;
      in_ready = 1'b1;
      out_flit = in_flit;
    end
  end

  assign fire       = in_valid && in_ready;
  assign take       = fire && !held && hv_in.first && !hv_in.last;
  assign release_rt = fire && held && hv_in.last;
  assign drop       = in_valid && !held && !hv_in.first;

  srp_route_hold #(.NPORTS(NPORTS)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .release_rt(release_rt),
    .new_sel   (dest_oh),
    .held      (held),
    .sel       (sel)
  );

  srp_drop_flag u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .drop (drop),
    .err  (err_drop)
  );

  assert_req_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_req));
  assert_req_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (out_req == '0));
  assert_stall_keeps_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && held) |=> (held && $stable(sel)));
endmodule

// File: tb/srp_input_ctrl_tb.sv
module srp_input_ctrl_tb_top;
  localparam int NP   = 5;
  localparam int PID  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [33:0]   in_flit;
  logic [NP-1:0] out_req;
  logic [NP-1:0] out_ready;
  logic [33:0]   out_flit;
  logic          err_drop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  srp_input_ctrl #(.NPORTS(NP), .PORT_ID(PID)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .out_req(out_req), .out_ready(out_ready),
    .out_flit(out_flit), .err_drop(err_drop)
  );

  function automatic logic [33:0] mk(bit f, bit l, logic [13:0] p, logic [17:0] d);
    return {f, l, p, d};
  endfunction

  function automatic logic [NP-1:0] exp_oh(int step);
    int idx = (step < PID) ? step : step + 1;
    return NP'(1) << idx;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [33:0] f, logic [NP-1:0] rdy);
    @(negedge clk);
    in_valid  = v;
    in_flit   = f;
    out_ready = rdy;
    #1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] eo;
    logic [33:0]   f;
    rst_n = 1'b0; in_valid = 1'b0; in_flit = '0; out_ready = '1;
    repeat (3) @(posedge clk);
    #1;
    chk(out_req == '0, "R9 req", 64'(out_req), 0);
    chk(err_drop == 1'b0, "R9 err", 64'(err_drop), 0);
    @(negedge clk); rst_n = 1'b1;

    // Sweep steps and route patterns: R1 R2 R3 R4 R5 R8
    for (int s = 0; s < 4; s++) begin
      for (int pat = 0; pat < 3; pat++) begin
        logic [13:0] p;
        p  = {12'(12'h5a3 * (pat + 1) + s), 2'(s)};
        eo = exp_oh(s);
        f  = mk(1, 0, p, 18'(18'h1234 + s * 7 + pat));
        drive(1, f, '1);
        chk(out_req == eo, "R1 header route", 64'(out_req), 64'(eo));
        chk(out_flit == {f[33:32], 2'b00, p[13:2], f[17:0]}, "R2 path shift",
            64'(out_flit), 64'({f[33:32], 2'b00, p[13:2], f[17:0]}));
        chk(in_ready == 1'b1, "R3 header ready", 64'(in_ready), 1);
        f = {2'b00, 32'(32'hc0de0000 + s * 16 + pat + 1)};
        drive(1, f, '1);
        chk(out_req == eo && out_flit == f, "R4 body same route", 64'(out_req), 64'(eo));
        f = mk(1, 0, 14'(14'h3ffd - s), 18'h2aaaa);
        drive(1, f, '1);
        chk(out_req == eo && out_flit == f, "R8 header while held", 64'(out_flit), 64'(f));
        drive(1, {2'b01, 32'hfeed0003}, ~eo);
        chk(in_ready == 1'b0 && out_req == eo, "R3 held stall", 64'(in_ready), 0);
        f = {2'b01, 32'(32'h0ddba110 + s)};
        drive(1, f, '1);
        chk(in_ready == 1'b1 && out_req == eo && out_flit == f, "R5 end flit", 64'(out_req), 64'(eo));
        drive(0, '0, '1);
        chk(out_req == '0, "R5 released quiet", 64'(out_req), 0);
        chk(err_drop == 1'b0, "R7 no false drop", 64'(err_drop), 0);
      end
    end

    // Back-to-back single-flit packets: release and decode coincide, R6
    for (int k = 0; k < 8; k++) begin
      int s = (k * 3 + 1) % 4;
      logic [13:0] p = {12'(k * 37), 2'(s)};
      eo = exp_oh(s);
      f  = mk(1, 1, p, 18'(k));
      drive(1, f, '1);
      chk(out_req == eo, "R6 single flit route", 64'(out_req), 64'(eo));
      chk(out_flit == {2'b11, 2'b00, p[13:2], f[17:0]}, "R6 single flit shift",
          64'(out_flit), 64'({2'b11, 2'b00, p[13:2], f[17:0]}));
    end
    drive(0, '0, '1);
    chk(out_req == '0, "R6 no stale req", 64'(out_req), 0);

    // Body with no route: R7
    drive(1, {2'b00, 32'h11112222}, '1);
    chk(in_ready == 1'b1 && out_req == '0, "R7 drop body", 64'(out_req), 0);
    drive(0, '0, '1);
    chk(err_drop == 1'b1, "R7 err raised", 64'(err_drop), 1);

    // Stalled header is not taken, following body is dropped: R3 R7
    eo = exp_oh(3);
    drive(1, mk(1, 0, 14'h0003, 18'h0), ~eo);
    chk(in_ready == 1'b0 && out_req == eo, "R3 idle stall", 64'(in_ready), 0);
    drive(1, {2'b00, 32'h33334444}, '1);
    chk(in_ready == 1'b1 && out_req == '0, "R3 no route after stall", 64'(out_req), 0);
    repeat (3) drive(0, '0, '1);
    chk(err_drop == 1'b1, "R7 err sticky", 64'(err_drop), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule